// File: doc/BRIEF.md
# Clocked Model of a Latched-Address SRAM with Shared Data Port

This block models a 256-word, 4-bit static memory with a shared data port. It is controlled by four active-low pins: a chip enable, two chip selects and a write enable. The model runs on a fast system clock. It registers the previous level of each control pin, so it can find edges by comparing that stored level with the current one.

The address is captured when the chip enable goes low. Later changes on the address pins are ignored until the next such fall. A read returns the word at the captured address. While the chip enable is high, the output value is held frozen.

A write window is open while all four controls are low together. The window closes when any one of them rises, and the word on the data input in that cycle is stored. The shared port is split into a data input, a data output and an output-enable flag; the flag means the port would drive.

Top module: `latched_io_sram`

## Requirements
- R1: During and after reset, `dout_en` is 0 until a read condition is applied.
- R2: `addr` is captured in the first clock cycle in which `ce_n` is sampled low after being high. Changes on `addr` while `ce_n` stays low have no effect on which word is read or written.
- R3: If either `sel_a_n` or `sel_b_n` is sampled high, `dout_en` is 0 in the next cycle.
- R4: With `ce_n`, `sel_a_n` and `sel_b_n` low and `we_n` high, the next cycle shows the word at the captured address on `dout`, with `dout_en` at 1.
- R5: While `ce_n` is high, `dout` keeps the value it had in the last cycle with `ce_n` low. `dout_en` still follows the selects and `we_n`.
- R6: A write happens only after a cycle in which all four controls were sampled low together. A sequence in which that never occurs leaves the memory unchanged.
- R7: The write window closes at the first cycle in which any one of `ce_n`, `sel_a_n`, `sel_b_n` or `we_n` is sampled high. The `din` value sampled in that cycle is stored at the captured address.
- R8: If `we_n` is sampled low, `dout_en` is 0 in the next cycle.
- R9: If `we_n` alone ends a write while `ce_n` and both selects stay low, the next cycle shows the just-written word on `dout`, with `dout_en` at 1.
- R10: With `ce_n` held low, the captured word can be read and rewritten several times in a row, and each read shows the latest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| sel_a_n | input | 1 | First chip select, active low |
| sel_b_n | input | 1 | Second chip select, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 8 | Word address |
| din | input | 4 | Data input side of the shared port |
| dout | output | 4 | Data output side of the shared port |
| dout_en | output | 1 | High when the port would drive `dout` |

## Verification
Every result is due exactly one clock edge after the pin levels that cause it. This holds for reads, for write-through of a just-written word, and for disable or hold of the output. A stored word becomes readable from the next access onward.

The bench changes the pins just after a falling clock edge. It then waits for one rising edge and compares at the following falling edge, so each check lands in the first cycle in which the result is due. Every location is written with an arithmetic pattern, using each of the four lines in turn to end the write. Every location is then read back, and the checks cover address hold, output hold and deselect along the way.

// File: rtl/latched_io_sram.sv
module latched_io_sram #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          sel_a_n,
  input  logic          sel_b_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_lat;
  logic          ce_q;
  logic          win_q;

  wire ce_fall = ce_q & ~ce_n;
  wire win_now = ~(ce_n | sel_a_n | sel_b_n | we_n);
  wire wr_fire = win_q & ~win_now;
  wire [AW-1:0] rd_addr = ce_fall ? addr : addr_lat;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[addr_lat] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      win_q    <= 1'b0;
      addr_lat <= '0;
      dout     <= '0;
      dout_en  <= 1'b0;
    end else begin
      ce_q    <= ce_n;
      win_q   <= win_now;
      dout_en <= ~sel_a_n & ~sel_b_n & we_n;
      if (ce_fall) addr_lat <= addr;
      if (!ce_n) dout <= wr_fire ? din : mem[rd_addr];
    end
  end
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          sel_a_n,
  input logic          sel_b_n,
  input logic          we_n,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic [AW-1:0] addr_lat
);
  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_a_n | sel_b_n) |-> !dout_en); // R3
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!we_n) |-> !dout_en); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> $stable(dout)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ce_n) && $past(!ce_n, 2)) |-> $stable(addr_lat)); // R2
endmodule

bind latched_io_sram sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel_a_n(sel_a_n),
  .sel_b_n(sel_b_n), .we_n(we_n), .dout(dout), .dout_en(dout_en),
  .addr_lat(addr_lat)
);

// File: tb/test_latched_io_sram.sv
module test_latched_io_sram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, sel_a_n = 1'b1, sel_b_n = 1'b1, we_n = 1'b1;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_en;
  int         checks = 0;
  int         errors = 0;
  logic [3:0] shadow [256];

  always #2 clk = ~clk;

  latched_io_sram i_latched_io_sram (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .we_n(we_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [3:0] pat(input int a);
    return 4'((a * 5 + 3) % 16);
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s1, input logic s2, input logic w,
                       input logic [7:0] a, input logic [3:0] d);
    ce_n = c; sel_a_n = s1; sel_b_n = s2; we_n = w; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic write_word(input int a, input logic [3:0] d, input int term);
    drive(1, 1, 1, 1, 8'(a), ~d);
    drive(0, 0, 0, 0, 8'(a), ~d);
    check("R8 output off while writing", {3'b0, dout_en}, 4'h0);
    drive(0, 0, 0, 0, ~8'(a), d ^ 4'h5);
    case (term)
      0: drive(1, 0, 0, 0, ~8'(a), d);
      1: drive(0, 1, 0, 0, ~8'(a), d);
      2: drive(0, 0, 1, 0, ~8'(a), d);
      default: begin
        drive(0, 0, 0, 1, ~8'(a), d);
        check("R9 write-through data", dout, d);
        check("R9 write-through enable", {3'b0, dout_en}, 4'h1);
      end
    endcase
    shadow[a] = d;
    drive(1, 1, 1, 1, 8'(a), ~d);
  endtask

  task automatic read_word(input int a);
    drive(0, 0, 0, 1, 8'(a), 4'h0);
    check("R4 read data", dout, shadow[a]);
    check("R4 read enable", {3'b0, dout_en}, 4'h1);
    drive(0, 0, 0, 1, 8'(a + 1), 4'h0);
    check("R2 address change ignored", dout, shadow[a]);
    drive(1, 0, 0, 1, 8'(a + 7), 4'h0);
    check("R5 hold after ce rise", dout, shadow[a]);
    check("R5 enable during hold", {3'b0, dout_en}, 4'h1);
    if (a % 2 == 0) drive(1, 1, 0, 1, 8'(a), 4'h0);
    else            drive(1, 0, 1, 1, 8'(a), 4'h0);
    check("R3 deselect off", {3'b0, dout_en}, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 enable in reset", {3'b0, dout_en}, 4'h0);
    rst_n = 1'b1;
    drive(1, 1, 1, 1, 8'h00, 4'h0);
    check("R1 enable after reset", {3'b0, dout_en}, 4'h0);

    for (int a = 0; a < 256; a++) write_word(a, pat(a), a % 4);
    for (int a = 0; a < 256; a++) read_word(a);

    // R6: window never fully formed (sel_b_n high) -> no write
    drive(0, 0, 1, 0, 8'h21, ~pat(33));
    drive(0, 0, 1, 1, 8'h21, ~pat(33));
    drive(1, 1, 1, 1, 8'h21, 4'h0);
    read_word(33);
    drive(0, 0, 0, 1, 8'h21, 4'h0);
    check("R6 no write without full window", dout, pat(33));
    drive(1, 1, 1, 1, 8'h21, 4'h0);

    // R10: read-modify-write repeatedly with ce_n held low
    drive(0, 0, 0, 1, 8'h42, 4'h0);
    check("R10 initial read", dout, pat(66));
    drive(0, 0, 0, 0, 8'h00, 4'h9);
    drive(0, 0, 0, 1, 8'h00, 4'hA);
    check("R10 first rewrite", dout, 4'hA);
    drive(0, 0, 0, 1, 8'h00, 4'h0);
    check("R10 read after first rewrite", dout, 4'hA);
    drive(0, 0, 0, 0, 8'hFF, 4'h1);
    drive(0, 0, 0, 1, 8'hFF, 4'h6);
    check("R10 second rewrite", dout, 4'h6);
    drive(1, 1, 1, 1, 8'h00, 4'h0);
    shadow[66] = 4'h6;
    read_word(66);
    check("R7 value from terminating cycle", shadow[66], 4'h6);
    read_word(0);
    check("R7 terminate by ce rise", dout, pat(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule